// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block sits in the column path of an SDRAM device or controller. When a READ or WRITE column command is registered, it produces one column address per clock for the rest of the burst. It also drives a strobe that marks each beat as valid and a one-cycle flag on the last beat of a fixed-length burst. That flag is what an auto-precharge sequencer waits for.

A burst can be 1, 2, 4 or 8 beats long, or it can cover a whole 256-column row. Fixed-length bursts step upward and wrap inside the block of columns aligned to the burst length. A full-page burst wraps around the row and keeps running until it is terminated. The generator accepts a new column command on any clock. A new command drops the burst in progress and starts again from its own column. A separate terminate input ends a burst early.

Top module: `sdram_colgen`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `col_valid` and `burst_done` are 0 and `col_addr` is 0.
- R2: After a clock edge that samples `cmd_valid` high, `col_valid` is 1 and `col_addr` equals the `cmd_col` sampled at that edge.
- R3: `len_sel` is decoded when the command is taken. If bit 2 is 0, the length is 2^`len_sel[1:0]` (0→1, 1→2, 2→4, 3→8 beats). An uninterrupted burst holds `col_valid` high for exactly that many consecutive cycles, and `col_valid` drops on the following cycle.
- R4: In a fixed-length burst of length N, each beat after the first is (previous+1) mod N within the N-aligned block. Bits above log2(N) keep the value of the starting column.
- R5: If bit 2 of `len_sel` is 1, the burst is full page. The address increases by 1 each cycle, wraps from 255 to 0, and `col_valid` stays high until a terminate or a new command.
- R6: A new command on any cycle, including the final beat, restarts the burst from its own column and length. When `cmd_valid` and `term_req` are sampled at the same edge, the command wins.
- R7: `term_req` sampled without `cmd_valid` makes `col_valid` 0 after that edge, and `burst_done` does not pulse for the terminated burst.
- R8: `burst_done` is 1 only on the final beat of a fixed-length burst, together with `col_valid`. It is never 1 during a full-page burst.
- R9: A change of `len_sel` during a burst has no effect on that burst's addresses or length.
- R10: While `col_valid` is 0 and no command arrives, `col_addr` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A READ or WRITE column command is presented |
| cmd_col | input | 8 | Starting column of the command |
| len_sel | input | 3 | Burst length code: bit 2 selects full page, bits 1:0 give log2 of the length |
| term_req | input | 1 | Burst terminate |
| col_addr | output | 8 | Column address of the current beat |
| col_valid | output | 1 | A burst beat is active this cycle |
| burst_done | output | 1 | Final beat of a fixed-length burst |

## Verification
Two functions can meet on one edge: a new column command and the end of the current burst. The end can be a terminate request or the natural last beat. The bench provokes both meetings. It raises `term_req` together with `cmd_valid` part-way through an 8-beat burst, and it issues a fresh command on the exact cycle that carries `burst_done`. In each case the scoreboard expects the new burst's first column, with `col_valid` unbroken, on the next cycle. A lost or doubled beat shows up as a mismatch in address, valid or done.

// File: rtl/sdram_colgen_pkg.sv
package sdram_colgen_pkg;

   // Per-cycle action chosen by the control logic for the burst registers.
   typedef enum logic [1:0] {
      ACT_HOLD = 2'd0,
      ACT_LOAD = 2'd1,
      ACT_ADV  = 2'd2,
      ACT_STOP = 2'd3
   } colgen_act_e;

endpackage

// File: rtl/colgen_len_decode.sv
// Turns the burst length code into a wrap mask and a last-beat index.
module colgen_len_decode #(
   parameter int COL_W = 8,
   parameter int SEL_W = 3,
   localparam int CODE_W = SEL_W - 1,
   localparam int CNT_W  = (1 << CODE_W) - 1
) (
   input  logic [SEL_W-1:0] len_sel,
   output logic [COL_W-1:0] wrap_mask,
   output logic [CNT_W-1:0] last_idx,
   output logic             page_mode
);
   logic [CODE_W-1:0] len_log;

   assign len_log   = len_sel[CODE_W-1:0];
   assign page_mode = len_sel[SEL_W-1];

   // Bit i of the mask is set when it lies inside the burst block.
   for (genvar i = 0; i < COL_W; i++) begin : g_mask
      assign wrap_mask[i] = page_mode | (int'(len_log) > i);
   end

   // Last beat index = length - 1, a run of ones below log2(length).
   for (genvar j = 0; j < CNT_W; j++) begin : g_last
      assign last_idx[j] = (int'(len_log) > j);
   end
endmodule

// File: rtl/colgen_wrap_inc.sv
// Next column: increment inside the masked bits, keep the rest.
module colgen_wrap_inc #(
   parameter int COL_W = 8
) (
   input  logic [COL_W-1:0] cur_col,
   input  logic [COL_W-1:0] wrap_mask,
   output logic [COL_W-1:0] next_col
);
   logic [COL_W-1:0] inc_col;

   assign inc_col = cur_col + 1'b1;

   for (genvar i = 0; i < COL_W; i++) begin : g_bit
      assign next_col[i] = wrap_mask[i] ? inc_col[i] : cur_col[i];
   end
endmodule

// File: rtl/colgen_ctrl.sv
// Chooses the register action; a command outranks terminate and burst end.
module colgen_ctrl
   import sdram_colgen_pkg::*;
(
   input  logic        cmd_valid,
   input  logic        term_req,
   input  logic        active,
   input  logic        page_mode,
   input  logic        last_beat,
   output colgen_act_e act
);
   always_comb begin
      if (cmd_valid)
         act = ACT_LOAD;
      else if (term_req || (active && !page_mode && last_beat))
         act = ACT_STOP;
      else if (active)
         act = ACT_ADV;
      else
         act = ACT_HOLD;
   end
endmodule

// File: rtl/sdram_colgen.sv
module sdram_colgen
   import sdram_colgen_pkg::*;
#(
   parameter int COL_W = 8,
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic [COL_W-1:0] cmd_col,
   input  logic [SEL_W-1:0] len_sel,
   input  logic             term_req,
   output logic [COL_W-1:0] col_addr,
   output logic             col_valid,
   output logic             burst_done
);
   localparam int CODE_W = SEL_W - 1;
   localparam int CNT_W  = (1 << CODE_W) - 1;

   if (SEL_W < 2) begin : g_bad_sel
      $error("SEL_W must be at least 2");
   end
   if (COL_W < CNT_W) begin : g_bad_col
      $error("COL_W too narrow for the longest fixed burst");
   end

   logic [COL_W-1:0] dec_mask;
   logic [CNT_W-1:0] dec_last;
   logic             dec_page;

   logic             active_q;
   logic [COL_W-1:0] addr_q;
   logic [COL_W-1:0] mask_q;
   logic [CNT_W-1:0] left_q;
   logic             page_q;
   logic [COL_W-1:0] next_col;
   logic             last_beat;
   colgen_act_e      act;

   colgen_len_decode #(.COL_W(COL_W), .SEL_W(SEL_W)) u_dec (
      .len_sel   (len_sel),
      .wrap_mask (dec_mask),
      .last_idx  (dec_last),
      .page_mode (dec_page)
   );

   colgen_wrap_inc #(.COL_W(COL_W)) u_inc (
      .cur_col   (addr_q),
      .wrap_mask (mask_q),
      .next_col  (next_col)
   );

   assign last_beat = (left_q == '0);

   colgen_ctrl u_ctrl (
      .cmd_valid (cmd_valid),
      .term_req  (term_req),
      .active    (active_q),
      .page_mode (page_q),
      .last_beat (last_beat),
      .act       (act)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         addr_q   <= '0;
         mask_q   <= '0;
         left_q   <= '0;
         page_q   <= 1'b0;
      end else begin
         unique case (act)
            ACT_LOAD: begin
               active_q <= 1'b1;
               addr_q   <= cmd_col;
               mask_q   <= dec_mask;
               left_q   <= dec_last;
               page_q   <= dec_page;
            end
            ACT_STOP: active_q <= 1'b0;
            ACT_ADV: begin
               addr_q <= next_col;
               if (!page_q) left_q <= left_q - 1'b1;
            end
            default: ;
         endcase
      end
   end

   assign col_addr   = addr_q;
   assign col_valid  = active_q;
   assign burst_done = active_q & ~page_q & last_beat;
endmodule

// File: rtl/sdram_colgen_chk.sv
module sdram_colgen_chk #(
   parameter int COL_W = 8,
   parameter int SEL_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_valid,
   input logic [COL_W-1:0] cmd_col,
   input logic [SEL_W-1:0] len_sel,
   input logic             term_req,
   input logic [COL_W-1:0] col_addr,
   input logic             col_valid,
   input logic             burst_done
);
   p_reset_idle_r1: assert property (@(posedge clk)
      !rst_n |=> (!col_valid && !burst_done));

   p_first_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> (col_valid && col_addr == $past(cmd_col)));

   p_done_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (burst_done && !cmd_valid) |=> !col_valid);

   p_step_moves_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (col_valid && !burst_done && !cmd_valid && !term_req)
      |=> (col_valid && col_addr != $past(col_addr)));

   p_term_stops_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (term_req && !cmd_valid) |=> (!col_valid && !burst_done));

   p_done_with_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
      burst_done |-> col_valid);

   p_page_no_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && len_sel[SEL_W-1]) |=> !burst_done);

   p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!col_valid && !cmd_valid) |=> $stable(col_addr));
endmodule

bind sdram_colgen sdram_colgen_chk #(.COL_W(COL_W), .SEL_W(SEL_W)) u_chk (.*);

// File: tb/sdram_colgen_tb.sv
module sdram_colgen_tb;
   localparam int CLK_PERIOD = 10;

   typedef struct {
      logic       v;
      logic [7:0] a;
      logic       d;
      string      tag;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic [7:0] cmd_col = 8'h00;
   logic [2:0] len_sel = 3'd0;
   logic       term_req = 1'b0;
   logic [7:0] col_addr;
   logic       col_valid;
   logic       burst_done;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;
   exp_t q[$];

   // Expectation state, built from the requirements
   bit       m_act = 1'b0;
   bit [7:0] m_base = 8'h00;
   bit [7:0] m_addr = 8'h00;
   int       m_n = 1;
   int       m_k = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sdram_colgen u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_col(cmd_col),
      .len_sel(len_sel), .term_req(term_req), .col_addr(col_addr),
      .col_valid(col_valid), .burst_done(burst_done)
   );

   function automatic bit [7:0] wrapf(bit [7:0] base, int k, int n);
      bit [7:0] s;
      s = base + 8'(k);
      if (n == 0) return s;
      return (base & ~8'(n - 1)) | (s & 8'(n - 1));
   endfunction

   task automatic report(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // Driver: apply one cycle of stimulus and push the expected result of that edge.
   task automatic drive(bit c, bit [7:0] col, bit [2:0] sel, bit t, string tag);
      exp_t e;
      @(negedge clk);
      cmd_valid = c; cmd_col = col; len_sel = sel; term_req = t;
      if (c) begin
         m_act = 1'b1; m_base = col; m_addr = col; m_k = 0;
         m_n = sel[2] ? 0 : (1 << sel[1:0]);
      end else if (t) begin
         m_act = 1'b0;
      end else if (m_act) begin
         if (m_n != 0 && m_k == m_n - 1) m_act = 1'b0;
         else begin
            m_k++;
            m_addr = wrapf(m_base, m_k, m_n);
         end
      end
      e.v = m_act; e.a = m_addr;
      e.d = m_act && (m_n != 0) && (m_k == m_n - 1);
      e.tag = tag;
      q.push_back(e);
   endtask

   task automatic idle(int n, string tag);
      for (int i = 0; i < n; i++) drive(1'b0, 8'h00, 3'd0, 1'b0, tag);
   endtask

   // Monitor: compare each edge's outputs with the queued expectation.
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (col_valid !== e.v || burst_done !== e.d || (e.v && col_addr !== e.a)
                || (!e.v && col_addr !== e.a)) begin
               fails++;
               $display("FAIL %s actual v=%0b a=%02h d=%0b expected v=%0b a=%02h d=%0b",
                        e.tag, col_valid, col_addr, burst_done, e.v, e.a, e.d);
            end
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 50000);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      report("R1", "valid in reset", int'(col_valid), 0);
      report("R1", "done in reset", int'(burst_done), 0);
      report("R1", "addr in reset", int'(col_addr), 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      report("R1", "valid after release", int'(col_valid), 0);

      // R3 single beat
      drive(1'b1, 8'h35, 3'd0, 1'b0, "R2");
      idle(3, "R3");
      // R4 two-beat wrap from odd column
      drive(1'b1, 8'h13, 3'd1, 1'b0, "R2");
      idle(2, "R4");
      // R4 four-beat wrap
      drive(1'b1, 8'h26, 3'd2, 1'b0, "R2");
      idle(5, "R4");
      // R9 eight-beat wrap with len_sel toggling mid-burst
      drive(1'b1, 8'hFD, 3'd3, 1'b0, "R2");
      for (int i = 0; i < 9; i++) drive(1'b0, 8'h00, 3'(i % 8), 1'b0, "R9");
      // R5 full page across the row end, then R7 terminate
      drive(1'b1, 8'hFE, 3'd4, 1'b0, "R2");
      idle(300, "R5");
      drive(1'b0, 8'h00, 3'd0, 1'b1, "R7");
      idle(3, "R10");
      // R7 terminate a four-beat burst early
      drive(1'b1, 8'h81, 3'd2, 1'b0, "R2");
      idle(1, "R4");
      drive(1'b0, 8'h00, 3'd0, 1'b1, "R7");
      idle(3, "R7");
      // R6 interrupt an eight-beat burst with a new four-beat one
      drive(1'b1, 8'h10, 3'd3, 1'b0, "R2");
      idle(2, "R4");
      drive(1'b1, 8'h41, 3'd2, 1'b0, "R6");
      idle(5, "R6");
      // R6 command and terminate on the same edge: command wins
      drive(1'b1, 8'h50, 3'd3, 1'b0, "R2");
      idle(2, "R4");
      drive(1'b1, 8'h60, 3'd1, 1'b1, "R6");
      idle(3, "R6");
      // R6 back-to-back command on the final beat
      drive(1'b1, 8'h7B, 3'd1, 1'b0, "R2");
      idle(1, "R8");
      drive(1'b1, 8'h9C, 3'd2, 1'b0, "R6");
      idle(5, "R8");
      // R8 full page never flags done; R6 a fixed burst replaces it
      drive(1'b1, 8'h02, 3'd7, 1'b0, "R2");
      idle(10, "R8");
      drive(1'b1, 8'hC7, 3'd3, 1'b0, "R6");
      idle(10, "R3");

      @(posedge clk);
      #2;
      @(posedge clk);
      #2;
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule